// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Edge and Level Interrupts

This block drives and samples sixteen general-purpose pins from a 32-bit register bus. Software writes output values and output enables. Each of those registers, and the interrupt status register, also has a set alias and a clear alias, so single bits can be changed without a read-modify-write. Every pin has its own configuration word that selects push-pull or open-drain drive, an interrupt trigger type and a wakeup permission.

Pin inputs are resynchronised into the bus clock domain. A detector on each pin compares the synchronised level with its value one cycle earlier and with the pin's trigger type. A hit latches the pin's status bit. The status bits are ORed into one interrupt line. A separate wakeup line is raised while a pin whose wakeup permission is set sees its selected level condition.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads zero and `pin_oe`, `irq` and `wake` are low.
- R2: A write to the output-value word (0x00) or the enable word (0x0C) replaces bits 15:0 of that register. Each bit drives one pin, and the result is read back at the same offset.
- R3: A write to a set alias (0x04 for output value, 0x10 for enable, 0x20 for status) sets each target bit whose written bit is 1 and leaves the other bits unchanged. Reading an alias returns zero.
- R4: A write to a clear alias (0x08 for output value, 0x14 for enable, 0x24 for status) clears each target bit whose written bit is 1 and leaves the other bits unchanged.
- R5: The input word (0x18) returns the pin levels in bits 15:0 two clock edges after they are applied, whatever each pin's enable is.
- R6: Trigger type 1 catches a rising edge, type 2 a falling edge and type 3 either edge. Types 0, 6 and 7 never catch anything. A caught condition sets the pin's status bit on the third clock edge after the pin changes.
- R7: Trigger type 4 catches a low level and type 5 a high level. While the level persists, the status bit is set again on every cycle, so it reappears immediately after a clear.
- R8: A status bit stays set until a bus write clears it.
- R9: If a detected condition and a bus clear hit the same status bit in the same cycle, the bit ends up set.
- R10: `irq` is high exactly when any status bit is set.
- R11: The configuration word for pin i is at 0x28 + 4*i. It holds drive mode in bit 2, trigger type in bits 9:7 and wakeup permission in bit 10, and its other bits read zero.
- R12: With drive mode 1 (open-drain), `pin_out` for that pin is 0 and `pin_oe` is the enable bit ANDed with the inverted output value. With drive mode 0, `pin_out` is the output value and `pin_oe` is the enable bit.
- R13: `wake` is high while some pin has wakeup permission, trigger type 4 or 5, and its synchronised level matches that type. With any other type the pin never raises `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output value to the pads |
| pin_oe | output | 16 | Output enable to the pads |
| irq | output | 1 | OR of all status bits |
| wake | output | 1 | Level-based wakeup request |

## Verification
Hardware detection and a software clear of the same status bit can fall in the same cycle. The bench provokes this by holding a pin at the level selected by a level trigger type and then writing the status clear alias. After the write it expects the bit to be set, not cleared. The sweep runs every pin with every trigger type through low, rising, high and falling phases, and clears the status bits between phases. Each expected status, interrupt and wakeup value is worked out from the type code and the current pin level.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int N  = 16,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic          irq,
  output logic          wake
);
  localparam int WW = AW - 2;
  localparam int CFG_BASE = 10;

  logic [WW-1:0] word;
  logic [N-1:0]  wd;
  logic [N-1:0]  out_q, oen_q, stat_q, stat_sw;
  logic [N-1:0]  s1, s2, prev;
  logic [N-1:0]  drv_q, wen_q, hit, lvl;
  logic [2:0]    typ_q [N];

  assign word = bus_addr[AW-1:2];
  assign wd   = bus_wdata[N-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0;
    end else begin
      s1 <= pin_in; s2 <= s1; prev <= s2;
    end

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic rise, fall;
    assign rise = s2[i] & ~prev[i];
    assign fall = ~s2[i] & prev[i];
    assign lvl[i] = (typ_q[i] == 3'd4 & ~s2[i]) | (typ_q[i] == 3'd5 & s2[i]);
    assign hit[i] = (typ_q[i] == 3'd1 & rise) | (typ_q[i] == 3'd2 & fall) |
                    (typ_q[i] == 3'd3 & (rise | fall)) | lvl[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        drv_q[i] <= 1'b0; typ_q[i] <= 3'd0; wen_q[i] <= 1'b0;
      end else if (bus_wr && word == WW'(CFG_BASE + i)) begin
        drv_q[i] <= bus_wdata[2];
        typ_q[i] <= bus_wdata[9:7];
        wen_q[i] <= bus_wdata[10];
      end
  end

  always_comb begin
    stat_sw = stat_q;
    if (bus_wr)
      case (word)
        WW'(7):  stat_sw = wd;
        WW'(8):  stat_sw = stat_q | wd;
        WW'(9):  stat_sw = stat_q & ~wd;
        default: ;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_q <= '0; oen_q <= '0; stat_q <= '0;
    end else begin
      stat_q <= stat_sw | hit;
      if (bus_wr)
        case (word)
          WW'(0):  out_q <= wd;
          WW'(1):  out_q <= out_q | wd;
          WW'(2):  out_q <= out_q & ~wd;
          WW'(3):  oen_q <= wd;
          WW'(4):  oen_q <= oen_q | wd;
          WW'(5):  oen_q <= oen_q & ~wd;
          default: ;
        endcase
    end

  always_comb begin
    bus_rdata = '0;
    case (word)
      WW'(0):  bus_rdata[N-1:0] = out_q;
      WW'(3):  bus_rdata[N-1:0] = oen_q;
      WW'(6):  bus_rdata[N-1:0] = s2;
      WW'(7):  bus_rdata[N-1:0] = stat_q;
      default:
        for (int k = 0; k < N; k++)
          if (word == WW'(CFG_BASE + k)) begin
            bus_rdata[2]   = drv_q[k];
            bus_rdata[9:7] = typ_q[k];
            bus_rdata[10]  = wen_q[k];
          end
    endcase
  end

  assign pin_out = out_q & ~drv_q;
  assign pin_oe  = oen_q & ~(drv_q & out_q);
  assign irq     = |stat_q;
  assign wake    = |(lvl & wen_q);
endmodule

module gpio_bank_chk #(
  parameter int N  = 16,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [N-1:0]  pin_oe,
  input logic          irq,
  input logic          wake,
  input logic [N-1:0]  data_q,
  input logic [N-1:0]  stat_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (pin_oe == '0 && !irq && !wake));

  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(0)) |=> data_q == $past(bus_wdata[N-1:0]));

  // R3
  data_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(4)) |=> (data_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0]));

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (stat_q & $past(stat_q)) == $past(stat_q));

  // R10
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr));
endmodule

bind gpio_bank gpio_bank_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq(irq), .wake(wake),
  .data_q(out_q), .stat_q(stat_q)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq, wake;
  int          errs = 0, checks = 0;

  gpio_bank uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .wake(wake));

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic stat_chk(string tag, int t, int p, bit lv, bit sticky);
    logic [31:0] v;
    bit hitl;
    hitl = (t == 4 && !lv) || (t == 5 && lv);
    rd(8'h1C, v);
    chk({tag, " status"}, v, (sticky || hitl) ? (32'd1 << p) : 32'd0);
    chk({tag, " R10 irq"}, {31'd0, irq}, {31'd0, sticky || hitl});
    chk({tag, " R13 wake"}, {31'd0, wake}, {31'd0, hitl});
  endtask

  initial begin
    #(200000 * 20);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit rise_hit, fall_hit;
    repeat (3) @(negedge clk);
    chk("R1 pin_oe", {16'd0, pin_oe}, 0);
    chk("R1 irq/wake", {30'd0, irq, wake}, 0);
    rst_n = 1;
    @(negedge clk);
    rd(8'h00, v); chk("R1 data", v, 0);
    rd(8'h0C, v); chk("R1 enable", v, 0);
    rd(8'h1C, v); chk("R1 status", v, 0);
    rd(8'h30, v); chk("R1 config", v, 0);

    wr(8'h00, 32'hFFFF_A5A5); rd(8'h00, v); chk("R2 data write", v, 32'h0000_A5A5);
    chk("R2 pin_out", {16'd0, pin_out}, 32'hA5A5);
    wr(8'h04, 32'h0F00);      rd(8'h00, v); chk("R3 data set", v, 32'hAFA5);
    rd(8'h04, v); chk("R3 alias reads zero", v, 0);
    wr(8'h08, 32'h0005);      rd(8'h00, v); chk("R4 data clear", v, 32'hAFA0);
    wr(8'h0C, 32'h1234);      rd(8'h0C, v); chk("R2 enable write", v, 32'h1234);
    chk("R2 pin_oe", {16'd0, pin_oe}, 32'h1234);
    wr(8'h10, 32'h8001);      rd(8'h0C, v); chk("R3 enable set", v, 32'h9235);
    wr(8'h14, 32'h0230);      rd(8'h0C, v); chk("R4 enable clear", v, 32'h9005);
    wr(8'h1C, 32'h00F0);      rd(8'h1C, v); chk("R8 status write", v, 32'h00F0);
    wr(8'h20, 32'h0101);      rd(8'h1C, v); chk("R3 status set", v, 32'h01F1);
    wr(8'h24, 32'h0030);      rd(8'h1C, v); chk("R4 status clear", v, 32'h01C1);
    repeat (3) @(negedge clk);
    rd(8'h1C, v); chk("R8 status holds", v, 32'h01C1);
    wr(8'h24, 32'hFFFF);      chk("R10 irq low", {31'd0, irq}, 0);

    wr(8'h0C, 32'h0000);
    pin_in = 16'hC35A;
    @(negedge clk); @(negedge clk);
    rd(8'h18, v); chk("R5 input", v, 32'hC35A);
    pin_in = 16'h0000;
    @(negedge clk); @(negedge clk);
    rd(8'h18, v); chk("R5 input low", v, 0);

    wr(8'h34, 32'hFFFF_FFFF); rd(8'h34, v); chk("R11 config fields", v, 32'h784);
    rd(8'h30, v); chk("R11 neighbour untouched", v, 0);
    wr(8'h34, 32'h0);

    wr(8'h00, 32'h00FF); wr(8'h0C, 32'hFFFF);
    for (int p = 0; p < 16; p++) begin
      logic [15:0] od;
      od = 16'd1 << p;
      wr(8'h28 + 8'(4 * p), 32'h4);
      chk("R12 open-drain out", {16'd0, pin_out}, {16'd0, 16'h00FF & ~od});
      chk("R12 open-drain oe", {16'd0, pin_oe}, {16'd0, 16'hFFFF & ~(od & 16'h00FF)});
      wr(8'h28 + 8'(4 * p), 32'h0);
    end
    wr(8'h00, 0); wr(8'h0C, 0);

    for (int p = 0; p < 16; p++) begin
      for (int t = 0; t < 8; t++) begin
        string tg;
        tg = $sformatf("pin%0d type%0d", p, t);
        rise_hit = (t == 1 || t == 3);
        fall_hit = (t == 2 || t == 3);
        wr(8'h28 + 8'(4 * p), (32'(t) << 7) | 32'h400);
        repeat (4) @(negedge clk);
        wr(8'h24, 32'hFFFF);
        stat_chk({tg, " R9 low"}, t, p, 0, 0);
        pin_in = 16'd1 << p;
        repeat (3) @(negedge clk);
        stat_chk({tg, " R6 R7 rise"}, t, p, 1, rise_hit || t == 4);
        wr(8'h24, 32'hFFFF);
        stat_chk({tg, " R7 high"}, t, p, 1, 0);
        pin_in = 16'd0;
        repeat (3) @(negedge clk);
        stat_chk({tg, " R6 R7 fall"}, t, p, 0, fall_hit || t == 5);
        wr(8'h24, 32'hFFFF);
        stat_chk({tg, " R9 low again"}, t, p, 0, 0);
        wr(8'h28 + 8'(4 * p), 32'h0);
        wr(8'h24, 32'hFFFF);
        rd(8'h1C, v); chk({tg, " R8 cleared"}, v, 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule